// File: doc/BRIEF.md
# Half-Bridge Channel Gate Controller

This block decides, cycle by cycle, which of the two switches of one half-bridge channel is switched on. Its command is a PWM level that has already been decoded into one of three states (drive high, drive low, released). A run enable, a supply-fault flag and a bootstrap-undervoltage flag arrive as plain control inputs. A signed switch-current sample arrives every clock. The block produces the high-side and low-side gate enables and an active-low fault output.

In normal operation the gates follow the command. The block inserts a break interval at every hand-over and keeps the high side on for a minimum time. Three things can override the command. Hysteretic overcurrent states take control when the switch current runs away. A freewheel hold keeps current flowing when the command is released while current is still large. A bootstrap interlock refuses a high command until the channel has been driven low once.

The current sample is a continuous bus that is read on every rising clock edge. It has no valid or ready signal, and the block never applies back-pressure. One LSB equals one ampere, and positive current flows out of the switch node into the load.

Top module: `hb_gate_ctrl`

## Requirements
- R1: Command encoding on `pwm_state`: 2'b01 is high, 2'b00 is low, and 2'b10 or 2'b11 is released. With no override active, a high command turns on only `hs_gate`, a low command turns on only `ls_gate`, and a release with the current inside the zero window leaves both gates off.
- R2: `hs_gate` and `ls_gate` are never high in the same cycle. Before `hs_gate` turns on, both gates have been off for at least DT_RISE cycles (1 by default). Before `ls_gate` turns on, both gates have been off for at least DT_FALL cycles (3 by default). When both gates have been off long enough, a gate turns on at the first edge that samples the new command.
- R3: Once `hs_gate` turns on, it stays on for at least MIN_ON cycles (20 by default) unless the channel is disabled.
- R4: While `hs_gate` has been on for at least BLANK_POS cycles (22 by default), a sample above OC_POS_A (+93) sets the positive overcurrent state at that edge. This state forces the high side off and the low side on, whatever the command. It is released at the first edge that samples a current at or below ZERO_POS_A (+5).
- R5: While `ls_gate` has been on for at least BLANK_NEG cycles (55 by default), a sample below OC_NEG_A (-45) sets the negative overcurrent state at that edge. This state forces the low side off and the high side on, whatever the command. It is released at the first edge that samples a current at or above ZERO_NEG_A (-8).
- R6: `fault_n` is low exactly while either overcurrent state is held. It falls in the cycle after the tripping sample.
- R7: When the command changes from high to released, a current above +5 forces a low-side freewheel, and a current below -8 keeps the high side on. Either hold ends at the first edge that samples the current inside the window [-8, +5]. A freewheel hold does not pull `fault_n` low.
- R8: When the command changes from low to released, a current below -8 forces a high-side freewheel, and a current above +5 keeps the low side on. Either hold ends in the same way as in R7.
- R9: After `boot_uv` has been sampled high, high commands leave both gates off until a low command is sampled while `boot_uv` is low. The low command is obeyed at once. This interlock never pulls `fault_n` low.
- R10: When `run_en` is low or `supply_fault` is high at an edge, both gates turn off at that edge (minimum on-time and overrides are ignored), and the overcurrent states clear, so `fault_n` is high.
- R11: While `rst_n` is low, both gates are off and `fault_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Channel enable; low forces both gates off |
| supply_fault | input | 1 | Any supply lockout; high forces both gates off |
| pwm_state | input | 2 | Decoded command: 00 low, 01 high, 1x released |
| boot_uv | input | 1 | Bootstrap supply undervolted |
| sw_current | input | CUR_W | Signed switch-current sample, 1 A per LSB |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| fault_n | output | 1 | Low while an overcurrent state is held |

## Verification
A stuck or wrongly set overcurrent state shows up on `fault_n` in the cycle after the sample, and on the gate pair one edge after that. A miscounted on-time age moves the trip edge by whole cycles, so the bench checks for the trip on the exact edge and also for the absence of a trip one cycle earlier. A wrong freewheel or interlock state shows up as a gate held on or off in the first cycle after the command changes. It is also checked on the edge where the current enters the zero window.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef enum logic [1:0] {
    CMD_LOW   = 2'b00,
    CMD_HIGH  = 2'b01,
    CMD_REL   = 2'b10,
    CMD_REL_B = 2'b11
  } pwm_cmd_e;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'b00,
    SIDE_HI   = 2'b01,
    SIDE_LO   = 2'b10
  } side_e;

endpackage

// File: rtl/hb_oc_guard.sv
module hb_oc_guard
  import hb_gate_pkg::*;
#(
  parameter int CUR_W      = 10,
  parameter int AGE_W      = 7,
  parameter int BLANK_POS  = 22,
  parameter int BLANK_NEG  = 55,
  parameter int OC_POS_A   = 93,
  parameter int OC_NEG_A   = -45,
  parameter int ZERO_POS_A = 5,
  parameter int ZERO_NEG_A = -8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    kill,
  input  logic                    hs_on,
  input  logic                    ls_on,
  input  logic [AGE_W-1:0]        on_age,
  input  logic signed [CUR_W-1:0] cur,
  output logic                    oc_pos,
  output logic                    oc_neg
);

  localparam logic [AGE_W-1:0]        BLK_P = AGE_W'(BLANK_POS);
  localparam logic [AGE_W-1:0]        BLK_N = AGE_W'(BLANK_NEG);
  localparam logic signed [CUR_W-1:0] TRIP_P = CUR_W'(OC_POS_A);
  localparam logic signed [CUR_W-1:0] TRIP_N = CUR_W'(OC_NEG_A);
  localparam logic signed [CUR_W-1:0] REL_P  = CUR_W'(ZERO_POS_A);
  localparam logic signed [CUR_W-1:0] REL_N  = CUR_W'(ZERO_NEG_A);

  logic pos_q, neg_q, pos_d, neg_d;
  logic trip_p, trip_n;

  // a trip is only armed once the gate has outlived its blanking window
  assign trip_p = hs_on && (on_age >= BLK_P) && (cur > TRIP_P);
  assign trip_n = ls_on && (on_age >= BLK_N) && (cur < TRIP_N);

  always_comb begin
    pos_d = pos_q;
    neg_d = neg_q;
    if (kill) begin
      pos_d = 1'b0;
      neg_d = 1'b0;
    end else if (pos_q) begin
      pos_d = !(cur <= REL_P);
    end else if (neg_q) begin
      neg_d = !(cur >= REL_N);
    end else begin
      pos_d = trip_p;
      neg_d = trip_n && !trip_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      neg_q <= neg_d;
    end
  end

  assign oc_pos = pos_q;
  assign oc_neg = neg_q;

endmodule

// File: rtl/hb_cmd_arbiter.sv
module hb_cmd_arbiter
  import hb_gate_pkg::*;
#(
  parameter int CUR_W      = 10,
  parameter int ZERO_POS_A = 5,
  parameter int ZERO_NEG_A = -8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    kill,
  input  pwm_cmd_e                cmd,
  input  logic                    boot_uv,
  input  logic signed [CUR_W-1:0] cur,
  input  logic                    oc_pos,
  input  logic                    oc_neg,
  output side_e                   want
);

  localparam logic signed [CUR_W-1:0] WIN_HI = CUR_W'(ZERO_POS_A);
  localparam logic signed [CUR_W-1:0] WIN_LO = CUR_W'(ZERO_NEG_A);

  logic  was_active_q;
  logic  lock_q;
  side_e hold_q, hold_now;
  logic  released, in_window;

  assign released  = (cmd == CMD_REL) || (cmd == CMD_REL_B);
  assign in_window = (cur >= WIN_LO) && (cur <= WIN_HI);

  // freewheel hold: chosen on the release edge from the current direction
  always_comb begin
    hold_now = SIDE_NONE;
    if (!kill && released) begin
      if (was_active_q) begin
        if (cur > WIN_HI)      hold_now = SIDE_LO;
        else if (cur < WIN_LO) hold_now = SIDE_HI;
      end else if (hold_q != SIDE_NONE && !in_window) begin
        hold_now = hold_q;
      end
    end
  end

  always_comb begin
    if (kill)                        want = SIDE_NONE;
    else if (oc_pos)                 want = SIDE_LO;
    else if (oc_neg)                 want = SIDE_HI;
    else if (hold_now != SIDE_NONE)  want = hold_now;
    else if (cmd == CMD_HIGH)        want = lock_q ? SIDE_NONE : SIDE_HI;
    else if (cmd == CMD_LOW)         want = SIDE_LO;
    else                             want = SIDE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_active_q <= 1'b0;
      lock_q       <= 1'b0;
      hold_q       <= SIDE_NONE;
    end else begin
      was_active_q <= !released && !kill;
      lock_q       <= boot_uv || (lock_q && (cmd != CMD_LOW));
      hold_q       <= hold_now;
    end
  end

endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
  import hb_gate_pkg::*;
#(
  parameter int AGE_W   = 7,
  parameter int MIN_ON  = 20,
  parameter int DT_RISE = 1,
  parameter int DT_FALL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  side_e            want,
  output logic             hs_gate,
  output logic             ls_gate,
  output logic [AGE_W-1:0] on_age
);

  localparam logic [AGE_W-1:0] ONE     = AGE_W'(1);
  localparam logic [AGE_W-1:0] SAT     = {AGE_W{1'b1}};
  localparam logic [AGE_W-1:0] MIN_C   = AGE_W'(MIN_ON);
  localparam logic [AGE_W-1:0] GAP_HI  = AGE_W'(DT_RISE);
  localparam logic [AGE_W-1:0] GAP_LO  = AGE_W'(DT_FALL);

  logic             hs_q, ls_q, hs_d, ls_d;
  logic [AGE_W-1:0] on_q, off_q, on_d, off_d;

  always_comb begin
    hs_d = hs_q;
    ls_d = ls_q;
    if (kill) begin
      hs_d = 1'b0;
      ls_d = 1'b0;
    end else if (hs_q) begin
      if (want != SIDE_HI && on_q >= MIN_C) hs_d = 1'b0;
    end else if (ls_q) begin
      if (want != SIDE_LO) ls_d = 1'b0;
    end else if (want == SIDE_HI && off_q >= GAP_HI) begin
      hs_d = 1'b1;
    end else if (want == SIDE_LO && off_q >= GAP_LO) begin
      ls_d = 1'b1;
    end
  end

  // on_q: cycles the present gate has been on; off_q: cycles both off
  always_comb begin
    if (hs_d || ls_d) begin
      off_d = '0;
      if (hs_q || ls_q) on_d = (on_q == SAT) ? on_q : on_q + ONE;
      else              on_d = ONE;
    end else begin
      on_d = '0;
      if (hs_q || ls_q) off_d = ONE;
      else              off_d = (off_q == SAT) ? off_q : off_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      on_q  <= '0;
      off_q <= SAT;
    end else begin
      hs_q  <= hs_d;
      ls_q  <= ls_d;
      on_q  <= on_d;
      off_q <= off_d;
    end
  end

  assign hs_gate = hs_q;
  assign ls_gate = ls_q;
  assign on_age  = on_q;

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int CUR_W      = 10,
  parameter int MIN_ON     = 20,
  parameter int DT_RISE    = 1,
  parameter int DT_FALL    = 3,
  parameter int BLANK_POS  = 22,
  parameter int BLANK_NEG  = 55,
  parameter int OC_POS_A   = 93,
  parameter int OC_NEG_A   = -45,
  parameter int ZERO_POS_A = 5,
  parameter int ZERO_NEG_A = -8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_en,
  input  logic                    supply_fault,
  input  logic [1:0]              pwm_state,
  input  logic                    boot_uv,
  input  logic signed [CUR_W-1:0] sw_current,
  output logic                    hs_gate,
  output logic                    ls_gate,
  output logic                    fault_n
);

  localparam int T_A     = (MIN_ON > BLANK_POS) ? MIN_ON : BLANK_POS;
  localparam int T_B     = (T_A > BLANK_NEG) ? T_A : BLANK_NEG;
  localparam int T_C     = (DT_RISE > DT_FALL) ? DT_RISE : DT_FALL;
  localparam int AGE_MAX = (T_B > T_C) ? T_B : T_C;
  localparam int AGE_W   = $clog2(AGE_MAX + 1) + 1;

  logic             kill;
  logic             oc_pos, oc_neg;
  side_e            want;
  logic [AGE_W-1:0] on_age;

  assign kill = !run_en || supply_fault;

  hb_cmd_arbiter #(
    .CUR_W(CUR_W), .ZERO_POS_A(ZERO_POS_A), .ZERO_NEG_A(ZERO_NEG_A)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .kill(kill),
    .cmd(pwm_cmd_e'(pwm_state)), .boot_uv(boot_uv), .cur(sw_current),
    .oc_pos(oc_pos), .oc_neg(oc_neg), .want(want)
  );

  hb_gate_sequencer #(
    .AGE_W(AGE_W), .MIN_ON(MIN_ON), .DT_RISE(DT_RISE), .DT_FALL(DT_FALL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .kill(kill), .want(want),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .on_age(on_age)
  );

  hb_oc_guard #(
    .CUR_W(CUR_W), .AGE_W(AGE_W), .BLANK_POS(BLANK_POS), .BLANK_NEG(BLANK_NEG),
    .OC_POS_A(OC_POS_A), .OC_NEG_A(OC_NEG_A),
    .ZERO_POS_A(ZERO_POS_A), .ZERO_NEG_A(ZERO_NEG_A)
  ) u_oc (
    .clk(clk), .rst_n(rst_n), .kill(kill),
    .hs_on(hs_gate), .ls_on(ls_gate), .on_age(on_age), .cur(sw_current),
    .oc_pos(oc_pos), .oc_neg(oc_neg)
  );

  assign fault_n = !(oc_pos || oc_neg);

endmodule

// File: rtl/hb_gate_ctrl_checks.sv
module hb_gate_ctrl_checks #(
  parameter int MIN_ON = 20
) (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic supply_fault,
  input logic hs_gate,
  input logic ls_gate,
  input logic fault_n
);

  logic        stop;
  logic [15:0] hs_run;

  assign stop = !run_en || supply_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hs_run <= '0;
    else if (!hs_gate)    hs_run <= '0;
    else if (hs_run != 16'hFFFF) hs_run <= hs_run + 16'd1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate)); // R2

  AST_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(!ls_gate)); // R2

  AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_gate) && !$past(stop)) |-> (hs_run >= 16'(MIN_ON))); // R3

  AST_FAULT_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(hs_gate || ls_gate)); // R6

  AST_KILL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!hs_gate && !ls_gate && fault_n)); // R10

endmodule

bind hb_gate_ctrl hb_gate_ctrl_checks #(.MIN_ON(MIN_ON)) u_checks (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .supply_fault(supply_fault),
  .hs_gate(hs_gate), .ls_gate(ls_gate), .fault_n(fault_n)
);

// File: tb/test_hb_gate_ctrl.sv
module test_hb_gate_ctrl;
  localparam int CLK_P = 10;
  localparam logic [1:0] P_LO = 2'b00, P_HI = 2'b01, P_Z = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b1, supply_fault = 1'b0, boot_uv = 1'b0;
  logic [1:0] pwm_state = P_Z;
  logic signed [9:0] sw_current = '0;
  logic hs_gate, ls_gate, fault_n;

  typedef struct {logic hs; logic ls; logic fn; string tag;} exp_t;
  exp_t exp_q[$];
  int checks = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hb_gate_ctrl i_hb_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .supply_fault(supply_fault),
    .pwm_state(pwm_state), .boot_uv(boot_uv), .sw_current(sw_current),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .fault_n(fault_n)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic [1:0] p, int amps);
    pwm_state  = p;
    sw_current = 10'(amps);
  endtask

  task automatic expect_out(logic h, logic l, logic f, string tag);
    exp_t e;
    e.hs = h; e.ls = l; e.fn = f; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops expectations just after each falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (hs_gate !== e.hs || ls_gate !== e.ls || fault_n !== e.fn) begin
          bad++;
          $display("FAIL %s: got hs=%b ls=%b fault_n=%b expected hs=%b ls=%b fault_n=%b",
                   e.tag, hs_gate, ls_gate, fault_n, e.hs, e.ls, e.fn);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    step(2);  expect_out(0, 0, 1, "R11 reset state");
    step(1);  rst_n = 1'b1;
    step(3);

    // R1 low, then high with rise gap
    drive(P_LO, 0);   step(1); expect_out(0, 1, 1, "R1 low command");
    step(5);          expect_out(0, 1, 1, "R1 low held");
    drive(P_HI, 0);   step(1); expect_out(0, 0, 1, "R2 break before high");
    step(1);          expect_out(1, 0, 1, "R1 high command");
    step(25);
    // R2 fall dead time
    drive(P_LO, 0);   step(1); expect_out(0, 0, 1, "R2 dead 1");
    step(1);          expect_out(0, 0, 1, "R2 dead 2");
    step(1);          expect_out(0, 0, 1, "R2 dead 3");
    step(1);          expect_out(0, 1, 1, "R2 low after gap");
    drive(P_Z, 0);    step(1); expect_out(0, 0, 1, "R1 release no current");
    step(5);

    // R3 minimum on-time
    drive(P_HI, 0);   step(1); expect_out(1, 0, 1, "R3 high on");
    drive(P_LO, 0);   step(19); expect_out(1, 0, 1, "R3 held at 20");
    step(1);          expect_out(0, 0, 1, "R3 released after 20");
    step(3);          expect_out(0, 1, 1, "R3 low follows");
    drive(P_Z, 0);    step(5);

    // R4 positive overcurrent
    drive(P_HI, 100); step(1); expect_out(1, 0, 1, "R4 high on");
    step(21);         expect_out(1, 0, 1, "R4 blanked");
    step(1);          expect_out(1, 0, 0, "R6 fault on trip");
    step(1);          expect_out(0, 0, 0, "R4 high forced off");
    step(3);          expect_out(0, 1, 0, "R4 low forced on");
    drive(P_HI, 50);  step(5); expect_out(0, 1, 0, "R4 hysteresis hold");
    drive(P_HI, 5);   step(1); expect_out(0, 1, 1, "R4 release");
    step(1);          expect_out(0, 0, 1, "R4 resume break");
    step(1);          expect_out(1, 0, 1, "R4 resume high");
    // R10 run low
    run_en = 1'b0;    step(1); expect_out(0, 0, 1, "R10 run low");
    run_en = 1'b1;    drive(P_Z, 0); step(5);

    // R5 negative overcurrent
    drive(P_LO, -60); step(1); expect_out(0, 1, 1, "R5 low on");
    step(54);         expect_out(0, 1, 1, "R5 blanked");
    step(1);          expect_out(0, 1, 0, "R6 fault on neg trip");
    step(1);          expect_out(0, 0, 0, "R5 low forced off");
    step(1);          expect_out(1, 0, 0, "R5 high forced on");
    step(25);         expect_out(1, 0, 0, "R5 hold");
    drive(P_LO, -8);  step(1); expect_out(1, 0, 1, "R5 release");
    step(1);          expect_out(0, 0, 1, "R5 resume break");
    step(3);          expect_out(0, 1, 1, "R5 resume low");

    // R10 supply fault clears overcurrent
    drive(P_HI, 100); step(1); expect_out(0, 0, 1, "R2 break");
    step(1);          expect_out(1, 0, 1, "R10 setup high");
    step(22);         expect_out(1, 0, 0, "R6 trip again");
    supply_fault = 1'b1; step(1); expect_out(0, 0, 1, "R10 supply fault");
    supply_fault = 1'b0; drive(P_Z, 0); step(5);

    // R7 freewheel from high
    drive(P_HI, 0);   step(1); expect_out(1, 0, 1, "R7 setup");
    step(25);
    drive(P_Z, 20);   step(1); expect_out(0, 0, 1, "R7 high off on release");
    step(3);          expect_out(0, 1, 1, "R7 low freewheel");
    step(5);          expect_out(0, 1, 1, "R7 freewheel held");
    drive(P_Z, 3);    step(1); expect_out(0, 0, 1, "R7 decayed");
    step(3);
    drive(P_HI, 0);   step(1); expect_out(1, 0, 1, "R7 setup back-flow");
    step(25);
    drive(P_Z, -10);  step(1); expect_out(1, 0, 1, "R7 high kept");
    step(5);          expect_out(1, 0, 1, "R7 high kept later");
    drive(P_Z, 0);    step(1); expect_out(0, 0, 1, "R7 back-flow decayed");

    // R8 freewheel from low
    drive(P_LO, 0);   step(5); expect_out(0, 1, 1, "R8 setup");
    drive(P_Z, -10);  step(1); expect_out(0, 0, 1, "R8 low off on release");
    step(1);          expect_out(1, 0, 1, "R8 high freewheel");
    step(25);
    drive(P_Z, 0);    step(1); expect_out(0, 0, 1, "R8 decayed");
    drive(P_LO, 0);   step(5); expect_out(0, 1, 1, "R8 setup 2");
    drive(P_Z, 10);   step(1); expect_out(0, 1, 1, "R8 low kept");
    step(3);          expect_out(0, 1, 1, "R8 low kept later");
    drive(P_Z, 0);    step(1); expect_out(0, 0, 1, "R8 decayed 2");

    // R9 bootstrap interlock
    drive(P_LO, 0);   step(5); expect_out(0, 1, 1, "R9 setup");
    boot_uv = 1'b1;   step(1);
    boot_uv = 1'b0;   drive(P_HI, 0); step(1); expect_out(0, 0, 1, "R9 high ignored");
    step(5);          expect_out(0, 0, 1, "R9 high still ignored");
    drive(P_LO, 0);   step(1); expect_out(0, 1, 1, "R9 low obeyed");
    drive(P_HI, 0);   step(1); expect_out(0, 0, 1, "R9 break");
    step(1);          expect_out(1, 0, 1, "R9 high after low");

    step(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule